// File: doc/BRIEF.md
# Digit-Strobed Configuration Strap Decoder

This block works out a counter's operating configuration from straps that are wired between the display digit strobes and four sense lines. The sense lines are function, range, control and external decimal point. The display scanner supplies two things each clock: the index of the digit currently strobed, and a flag that marks the late half of that digit's slot. A sense line is taken as connected to a digit when it is active during the late half of that digit's slot. The block collects these hits over one full scan frame. At the frame boundary it decodes the hits into a measurement function, a gate range, a set of control flags and an external decimal-point position.

Decoded values are not taken up at once. A value is committed only when two full frames in a row decode to the same thing. When the committed function or range changes, the block emits a one-cycle pulse so that the measurement logic can abandon the measurement in progress. The control line may be strapped to several digits at once, and each of those digits raises its own flag. A parameter selects the sense polarity: active-high for common-anode boards, active-low for common-cathode boards.

Top module: `strap_decoder`

## Requirements
- R1: A sense line counts as strapped to digit k only when it is active in a cycle where `slot_late`=1 and `digit_idx`=k (`digit_idx` 0 is D1 and 7 is D8). Activity while `slot_late`=0 is ignored.
- R2: A frame whose function hits are exactly one of these digits decodes to the `fn_sel` code shown: D1→0 (frequency), D8→1 (period), D2→2 (ratio), D5→3 (interval), D4→4 (unit count), D3→5 (oscillator self-test).
- R3: A frame whose range hits are exactly one of these digits decodes to the `rng_sel` code shown: D1→0, D2→1, D3→2, D4→3 (ranges 1 to 4), D5→4 (external range input).
- R4: Control hits set independent flags, and several of them may be set in one frame: D8→`disp_test`, D2→`osc_1mhz`, D1→`ext_osc`, D3→`ext_dp_en`.
- R5: `disp_off` is 1 exactly when the committed control flags include D4 and `hold` is 1. It drops in the same cycle that `hold` falls.
- R6: With parameter ACTIVE_LOW=1, inverted sense lines produce outputs identical to those of the active-high build.
- R7: While `disp_off` is 1, the sense lines are ignored: no hits are collected, no frame is decoded, and every committed value stays as it is.
- R8: The external decimal-point position is accepted only when exactly one digit among D1..D7 is hit. A D8 hit, or more than one hit, decodes to "none". `ext_dp_valid` equals the committed position's validity ANDed with `ext_dp_en`, and `ext_dp_pos` is the digit index.
- R9: A frame ends on the clock edge where the previous `digit_idx` was 0 and the current one is not 0. A decoded value is committed at that edge only if the frame that just ended and the frame before it decode to the same value. Alternating values never commit.
- R10: `mode_chg` is a one-cycle pulse, registered at the commit edge, that fires exactly when the committed function or range takes a new value. A function change and a range change at the same edge give a single pulse.
- R11: A frame with no valid function decode (no hit, an unmapped digit, or several hits) leaves `fn_sel` unchanged. The same holds for range.
- R12: After reset, `fn_sel`=0, `rng_sel`=0, all control flags are 0, `ext_dp_valid`=0 and `mode_chg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| digit_idx | input | 3 | Digit currently strobed (0 = D1) |
| slot_late | input | 1 | High in the late half of the digit slot |
| hold | input | 1 | Hold request |
| fn_line | input | 1 | Function sense line |
| rng_line | input | 1 | Range sense line |
| ctl_line | input | 1 | Control sense line |
| dp_line | input | 1 | External decimal-point sense line |
| fn_sel | output | 3 | Committed function code |
| rng_sel | output | 3 | Committed range code |
| mode_chg | output | 1 | Pulse on function or range change |
| disp_off | output | 1 | Display drivers off |
| disp_test | output | 1 | Display test |
| osc_1mhz | output | 1 | 1 MHz timebase select |
| ext_osc | output | 1 | External timebase select |
| ext_dp_en | output | 1 | External decimal point enabled |
| ext_dp_valid | output | 1 | External decimal-point position valid |
| ext_dp_pos | output | 3 | External decimal-point digit index |

## Verification
The function commit and the range commit can land on the same frame boundary, and they must then produce a single change pulse. The bench provokes this directly after reset by strapping a new function and a new range together. A per-cycle reference model then judges the pulse count and timing. Entry into display-off is also provoked while function straps change, to confirm that the freeze wins over a pending commit.

// File: rtl/strap_decoder.sv
`timescale 1ns/1ps
module strap_decoder #(
  parameter bit ACTIVE_LOW = 1'b0,
  parameter int NDIG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NDIG)-1:0] digit_idx,
  input  logic                    slot_late,
  input  logic                    hold,
  input  logic                    fn_line,
  input  logic                    rng_line,
  input  logic                    ctl_line,
  input  logic                    dp_line,
  output logic [2:0]              fn_sel,
  output logic [2:0]              rng_sel,
  output logic                    mode_chg,
  output logic                    disp_off,
  output logic                    disp_test,
  output logic                    osc_1mhz,
  output logic                    ext_osc,
  output logic                    ext_dp_en,
  output logic                    ext_dp_valid,
  output logic [$clog2(NDIG)-1:0] ext_dp_pos
);
  localparam int IW = $clog2(NDIG);
  localparam logic [NDIG-1:0] ONE = NDIG'(1);
  localparam int LAST = NDIG - 1;

  logic [3:0]      sense;
  logic [NDIG-1:0] strobe, fn_m, rg_m, ct_m, dp_m;
  logic [IW-1:0]   prev_idx;
  logic            frame_end;

  logic            fn_nv, rg_nv, dp_ok;
  logic [2:0]      fn_n, rg_n;
  logic [IW-1:0]   dp_n;
  logic [4:0]      ct_n;

  logic [2:0]      fn_c, rg_c;
  logic            fn_cv, rg_cv, ct_cv, dp_cv, dp_cok, dp_qok;
  logic [4:0]      ct_c, ct_q;
  logic [IW-1:0]   dp_c;
  logic            fn_commit, rg_commit;

  assign sense     = {fn_line, rng_line, ctl_line, dp_line} ^ {4{ACTIVE_LOW}};
  assign strobe    = slot_late ? (ONE << digit_idx) : '0;
  assign frame_end = (prev_idx == '0) && (digit_idx != '0);

  always_comb begin
    fn_nv = 1'b1;
    case (fn_m)
      ONE << 0:    fn_n = 3'd0;
      ONE << LAST: fn_n = 3'd1;
      ONE << 1:    fn_n = 3'd2;
      ONE << 4:    fn_n = 3'd3;
      ONE << 3:    fn_n = 3'd4;
      ONE << 2:    fn_n = 3'd5;
      default: begin fn_n = 3'd0; fn_nv = 1'b0; end
    endcase
    rg_nv = 1'b1;
    case (rg_m)
      ONE << 0: rg_n = 3'd0;
      ONE << 1: rg_n = 3'd1;
      ONE << 2: rg_n = 3'd2;
      ONE << 3: rg_n = 3'd3;
      ONE << 4: rg_n = 3'd4;
      default: begin rg_n = 3'd0; rg_nv = 1'b0; end
    endcase
    dp_ok = $onehot(dp_m) && !dp_m[LAST];
    dp_n  = '0;
    for (int k = 0; k < NDIG; k++)
      if (dp_ok && dp_m[k]) dp_n = IW'(k);
  end

  assign ct_n      = {ct_m[2], ct_m[3], ct_m[0], ct_m[1], ct_m[LAST]};
  assign fn_commit = fn_nv && fn_cv && (fn_n == fn_c);
  assign rg_commit = rg_nv && rg_cv && (rg_n == rg_c);

  assign disp_off     = ct_q[3] & hold;
  assign ext_dp_en    = ct_q[4];
  assign ext_osc      = ct_q[2];
  assign osc_1mhz     = ct_q[1];
  assign disp_test    = ct_q[0];
  assign ext_dp_valid = dp_qok & ct_q[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {fn_m, rg_m, ct_m, dp_m} <= '0;
      prev_idx <= '0;
      {fn_c, rg_c, ct_c, dp_c} <= '0;
      {fn_cv, rg_cv, ct_cv, dp_cv, dp_cok} <= '0;
      fn_sel <= '0; rng_sel <= '0; ct_q <= '0;
      ext_dp_pos <= '0; dp_qok <= 1'b0;
      mode_chg <= 1'b0;
    end else begin
      prev_idx <= digit_idx;
      mode_chg <= 1'b0;
      if (disp_off) begin
        {fn_m, rg_m, ct_m, dp_m} <= '0;
      end else if (frame_end) begin
        fn_m <= strobe & {NDIG{sense[3]}};
        rg_m <= strobe & {NDIG{sense[2]}};
        ct_m <= strobe & {NDIG{sense[1]}};
        dp_m <= strobe & {NDIG{sense[0]}};
        fn_c <= fn_n; fn_cv <= fn_nv;
        rg_c <= rg_n; rg_cv <= rg_nv;
        ct_c <= ct_n; ct_cv <= 1'b1;
        dp_c <= dp_n; dp_cok <= dp_ok; dp_cv <= 1'b1;
        if (fn_commit) fn_sel <= fn_n;
        if (rg_commit) rng_sel <= rg_n;
        if (ct_cv && ct_c == ct_n) ct_q <= ct_n;
        if (dp_cv && dp_c == dp_n && dp_cok == dp_ok) begin
          ext_dp_pos <= dp_n;
          dp_qok     <= dp_ok;
        end
        mode_chg <= (fn_commit && fn_n != fn_sel) || (rg_commit && rg_n != rng_sel);
      end else begin
        fn_m <= fn_m | (strobe & {NDIG{sense[3]}});
        rg_m <= rg_m | (strobe & {NDIG{sense[2]}});
        ct_m <= ct_m | (strobe & {NDIG{sense[1]}});
        dp_m <= dp_m | (strobe & {NDIG{sense[0]}});
      end
    end
  end
endmodule

// File: rtl/strap_decoder_chk.sv
`timescale 1ns/1ps
module strap_decoder_chk #(
  parameter int NDIG = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    hold,
  input logic [2:0]              fn_sel,
  input logic [2:0]              rng_sel,
  input logic                    mode_chg,
  input logic                    disp_off,
  input logic                    ext_osc,
  input logic                    disp_test,
  input logic                    ext_dp_valid,
  input logic [$clog2(NDIG)-1:0] ext_dp_pos
);
  assert_chg_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> (fn_sel != $past(fn_sel) || rng_sel != $past(rng_sel)));
  assert_chg_needed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel != $past(fn_sel) || rng_sel != $past(rng_sel)) |-> mode_chg);
  assert_chg_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !mode_chg);
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |=> $stable(fn_sel) && $stable(rng_sel) && $stable(ext_osc) && $stable(disp_test));
  assert_dp_not_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_dp_valid |-> ext_dp_pos != NDIG - 1);
  assert_fn_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fn_sel <= 3'd5);
  assert_rng_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rng_sel <= 3'd4);
  assert_off_needs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> !disp_off);
endmodule

bind strap_decoder strap_decoder_chk #(.NDIG(NDIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .fn_sel(fn_sel), .rng_sel(rng_sel),
  .mode_chg(mode_chg), .disp_off(disp_off), .ext_osc(ext_osc),
  .disp_test(disp_test), .ext_dp_valid(ext_dp_valid), .ext_dp_pos(ext_dp_pos)
);

// File: tb/test_strap_decoder.sv
`timescale 1ns/1ps
module test_strap_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] digit_idx = '0;
  logic slot_late = 1'b0, hold = 1'b0;
  logic fl = 1'b0, rl = 1'b0, cl = 1'b0, dl = 1'b0;

  logic [2:0] fn_sel, rng_sel, ext_dp_pos, fn_sel_n, rng_sel_n, ext_dp_pos_n;
  logic mode_chg, disp_off, disp_test, osc_1mhz, ext_osc, ext_dp_en, ext_dp_valid;
  logic mode_chg_n, disp_off_n, disp_test_n, osc_1mhz_n, ext_osc_n, ext_dp_en_n, ext_dp_valid_n;

  always #4 clk = ~clk;

  strap_decoder i_strap_decoder (
    .clk(clk), .rst_n(rst_n), .digit_idx(digit_idx), .slot_late(slot_late), .hold(hold),
    .fn_line(fl), .rng_line(rl), .ctl_line(cl), .dp_line(dl),
    .fn_sel(fn_sel), .rng_sel(rng_sel), .mode_chg(mode_chg), .disp_off(disp_off),
    .disp_test(disp_test), .osc_1mhz(osc_1mhz), .ext_osc(ext_osc), .ext_dp_en(ext_dp_en),
    .ext_dp_valid(ext_dp_valid), .ext_dp_pos(ext_dp_pos));

  strap_decoder #(.ACTIVE_LOW(1'b1)) i_strap_decoder_n (
    .clk(clk), .rst_n(rst_n), .digit_idx(digit_idx), .slot_late(slot_late), .hold(hold),
    .fn_line(~fl), .rng_line(~rl), .ctl_line(~cl), .dp_line(~dl),
    .fn_sel(fn_sel_n), .rng_sel(rng_sel_n), .mode_chg(mode_chg_n), .disp_off(disp_off_n),
    .disp_test(disp_test_n), .osc_1mhz(osc_1mhz_n), .ext_osc(ext_osc_n), .ext_dp_en(ext_dp_en_n),
    .ext_dp_valid(ext_dp_valid_n), .ext_dp_pos(ext_dp_pos_n));

  int checks = 0, failures = 0, chg_cnt = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model
  int mf, mr, mc, md, pidx;
  int cf, cr, cc, cd;
  int qf, qr, qc, qd, mchg;

  function automatic int dec_fn(input int m);
    case (m)
      1: return 0; 128: return 1; 2: return 2; 16: return 3; 8: return 4; 4: return 5;
      default: return -1;
    endcase
  endfunction
  function automatic int dec_rg(input int m);
    case (m)
      1: return 0; 2: return 1; 4: return 2; 8: return 3; 16: return 4;
      default: return -1;
    endcase
  endfunction
  function automatic int dec_dp(input int m);
    if ($countones(m) == 1 && m < 128) return $clog2(m);
    return 8;
  endfunction
  function automatic int dec_ct(input int m);
    return ((m >> 2 & 1) << 4) | ((m >> 3 & 1) << 3) | ((m & 1) << 2) | ((m >> 1 & 1) << 1) | (m >> 7 & 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mf = 0; mr = 0; mc = 0; md = 0; pidx = 0;
      cf = -1; cr = -1; cc = -1; cd = -1;
      qf = 0; qr = 0; qc = 0; qd = 8; mchg = 0;
    end else begin
      int s, nf, nr, nc, nd;
      s = slot_late ? (1 << digit_idx) : 0;
      mchg = 0;
      if (((qc >> 3) & 1) && hold) begin
        mf = 0; mr = 0; mc = 0; md = 0;
      end else if (pidx == 0 && digit_idx != 0) begin
        nf = dec_fn(mf); nr = dec_rg(mr); nc = dec_ct(mc); nd = dec_dp(md);
        if (nf >= 0 && nf == cf && nf != qf) mchg = 1;
        if (nr >= 0 && nr == cr && nr != qr) mchg = 1;
        if (nf >= 0 && nf == cf) qf = nf;
        if (nr >= 0 && nr == cr) qr = nr;
        if (nc == cc) qc = nc;
        if (nd == cd) qd = nd;
        cf = nf; cr = nr; cc = nc; cd = nd;
        mf = fl ? s : 0; mr = rl ? s : 0; mc = cl ? s : 0; md = dl ? s : 0;
      end else begin
        mf |= fl ? s : 0; mr |= rl ? s : 0; mc |= cl ? s : 0; md |= dl ? s : 0;
      end
      pidx = digit_idx;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (mode_chg) chg_cnt++;
      chk("R2", "fn_sel model", fn_sel, qf);
      chk("R3", "rng_sel model", rng_sel, qr);
      chk("R10", "mode_chg model", mode_chg, mchg);
      chk("R5", "disp_off model", disp_off, ((qc >> 3) & 1) & hold);
      chk("R4", "disp_test model", disp_test, qc & 1);
      chk("R4", "osc_1mhz model", osc_1mhz, (qc >> 1) & 1);
      chk("R4", "ext_osc model", ext_osc, (qc >> 2) & 1);
      chk("R4", "ext_dp_en model", ext_dp_en, (qc >> 4) & 1);
      chk("R8", "ext_dp_valid model", ext_dp_valid, (qd < 8) && ((qc >> 4) & 1));
      if (qd < 8) chk("R8", "ext_dp_pos model", ext_dp_pos, qd);
      chk("R6", "polarity match", {fn_sel_n, rng_sel_n, mode_chg_n, disp_off_n, disp_test_n,
          osc_1mhz_n, ext_osc_n, ext_dp_en_n, ext_dp_valid_n, ext_dp_pos_n},
          {fn_sel, rng_sel, mode_chg, disp_off, disp_test, osc_1mhz, ext_osc, ext_dp_en,
          ext_dp_valid, ext_dp_pos});
    end
  end

  // one scan frame D8..D1, four cycles per slot, late half = last two
  task automatic run_frame(input int fd, input int rd, input int cm, input int dm, input bit noise = 1'b0);
    for (int s = 7; s >= 0; s--)
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        digit_idx = 3'(s);
        slot_late = (c >= 2);
        fl = (s == fd) || (noise && c < 2 && s == 1);
        rl = (s == rd);
        cl = cm[s];
        dl = dm[s];
      end
  endtask

  task automatic frames(input int n, input int fd, input int rd, input int cm, input int dm);
    for (int i = 0; i < n; i++) run_frame(fd, rd, cm, dm);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "reset fn_sel", fn_sel, 0);
    chk("R12", "reset rng_sel", rng_sel, 0);
    chk("R12", "reset flags", {disp_off, disp_test, osc_1mhz, ext_osc, ext_dp_en}, 0);
    chk("R12", "reset ext_dp_valid", ext_dp_valid, 0);
    chk("R12", "reset mode_chg", mode_chg, 0);
    @(negedge clk); rst_n = 1'b1;

    chg_cnt = 0;
    frames(3, 7, 1, 0, 0);
    chk("R2", "period on D8", fn_sel, 1);
    chk("R3", "range 2 on D2", rng_sel, 1);
    chk("R10", "joint change single pulse", chg_cnt, 1);

    chg_cnt = 0;
    for (int i = 0; i < 4; i++) run_frame((i % 2) ? 4 : 1, 1, 0, 0);
    chk("R9", "alternating never commits", fn_sel, 1);
    chk("R10", "no pulse while alternating", chg_cnt, 0);

    begin
      int digs[6] = '{0, 7, 1, 4, 3, 2};
      for (int k = 0; k < 6; k++) begin
        frames(3, digs[k], 1, 0, 0);
        chk("R2", "function map", fn_sel, k);
      end
    end

    frames(3, 2, 4, 0, 0);
    chk("R3", "external range on D5", rng_sel, 4);
    frames(3, 2, 5, 0, 0);
    chk("R11", "unmapped range digit keeps", rng_sel, 4);
    frames(3, -1, 0, 0, 0);
    chk("R11", "no function digit keeps", fn_sel, 5);

    for (int i = 0; i < 3; i++) run_frame(7, 0, 0, 0, 1'b1);
    chk("R1", "early-half activity ignored", fn_sel, 1);

    frames(3, 7, 0, 8'h83, 0);
    chk("R4", "combined test", disp_test, 1);
    chk("R4", "combined 1MHz", osc_1mhz, 1);
    chk("R4", "combined ext osc", ext_osc, 1);
    chk("R4", "combined dp enable", ext_dp_en, 0);

    frames(3, 7, 0, 8'h04, 8'h80);
    chk("R8", "D8 decimal point rejected", ext_dp_valid, 0);
    frames(3, 7, 0, 8'h04, 8'h04);
    chk("R8", "D3 decimal point valid", ext_dp_valid, 1);
    chk("R8", "D3 decimal point position", ext_dp_pos, 2);
    frames(3, 7, 0, 8'h04, 8'h0C);
    chk("R8", "two decimal points rejected", ext_dp_valid, 0);

    @(negedge clk); hold = 1'b1;
    frames(3, 7, 0, 8'h00, 0);
    chk("R5", "hold alone no display off", disp_off, 0);
    frames(3, 7, 0, 8'h08, 0);
    chk("R5", "display off with D4 and hold", disp_off, 1);
    chg_cnt = 0;
    frames(3, 0, 2, 8'h80, 0);
    chk("R7", "function frozen", fn_sel, 1);
    chk("R7", "range frozen", rng_sel, 0);
    chk("R7", "flags frozen", disp_test, 0);
    chk("R7", "no pulse while off", chg_cnt, 0);
    @(negedge clk); hold = 1'b0;
    #1;
    chk("R5", "display off drops with hold", disp_off, 0);
    frames(3, 0, 2, 8'h00, 0);
    chk("R9", "resumes after hold", fn_sel, 0);
    chk("R9", "range resumes", rng_sel, 2);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule